// File: doc/BRIEF.md
# Radix-2 Booth Sequential Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits one recoded bit at a time. A pulse on `start` while the unit is idle latches both operands. The unit then runs for exactly `WIDTH` steps. In each step it looks at the lowest bit of the shifting multiplier together with the bit that left that position on the previous step. That bit pair decides whether the multiplicand is added to the running high half, subtracted from it, or left out. The whole accumulator/multiplier/history chain then shifts right arithmetically.

Because the add/subtract choice comes from transitions between neighbouring multiplier bits, negative multipliers and negative multiplicands need no pre-complementing and no final correction. The accumulator carries one guard bit above the operand width, so the most negative multiplicand can be subtracted without wrapping. The full `2*WIDTH`-bit signed product is available when `done` pulses. It stays on `product` until the next accepted start.

Top module: `booth_seq_mul`

## Requirements
- R1: While `rst` is sampled high at a clock edge, the unit returns to idle: `busy`=0, `done`=0 and `product`=0 after that edge.
- R2: A `start` sampled high while `busy`=0 latches `mcand` and `mplier`, and `busy` is 1 after that edge.
- R3: Exactly `WIDTH` steps follow an accepted start. `done` is high for exactly one cycle, beginning `WIDTH` clock edges after the start edge, and `busy` falls on the same edge that raises `done`.
- R4: `product` is the signed product of the two operands read as two's complement, for every sign combination. With 5-bit operands, +13 × −6 gives −78 and −13 × +11 gives −143.
- R5: The most negative operand value is multiplied correctly in either position, including most-negative × most-negative (+16384 at 8 bits). At `done`, the accumulator guard bit equals the accumulator's top operand bit.
- R6: Recoding uses the pair (current multiplier LSB, previous shifted-out bit), and the previous bit is 0 before the first step. Pair 01 adds M, pair 10 subtracts M by adding its two's complement, and pairs 00 and 11 add nothing. So a multiplier of 0 gives 0 and a multiplier of all ones gives −M.
- R7: A `start` pulse while `busy`=1 is ignored. Neither the operands in use nor the completion timing change.
- R8: While idle and without a new start, `product` holds its value.
- R9: The step counter never reaches `WIDTH` while the unit is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a new multiplication (taken only when idle) |
| mcand | input | WIDTH | Multiplicand, two's complement |
| mplier | input | WIDTH | Multiplier, two's complement |
| busy | output | 1 | High while the steps are running |
| done | output | 1 | One-cycle pulse when the product is ready |
| product | output | 2*WIDTH | Signed product, valid from `done` until the next start |

## Verification
Several properties are checked on every cycle:
- `done` is a single-cycle pulse and never coincides with `busy`.
- An idle start always raises `busy`.
- The product is frozen while idle.
- The step counter stays in range.
- The guard bit agrees with the sign when a result completes.

The numeric correctness of the product cannot be stated as a cycle-local property. The bench's scenarios show it for mixed signs, the 5-bit worked examples, the most negative values, and multipliers of all zeros, all ones and alternating bits. The same holds for the exact latency and for the rejection of a start that arrives mid-run.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;
   typedef enum logic [1:0] {
      BOP_NONE = 2'd0,
      BOP_ADD  = 2'd1,
      BOP_SUB  = 2'd2
   } booth_op_e;

   typedef enum logic {
      MS_IDLE = 1'b0,
      MS_RUN  = 1'b1
   } mul_state_e;
endpackage

// File: rtl/booth_recode.sv
module booth_recode
   import booth_mul_pkg::*;
(
   input  logic      cur_lsb,
   input  logic      prev_bit,
   output booth_op_e op
);
   always_comb begin
      unique case ({cur_lsb, prev_bit})
         2'b01:   op = BOP_ADD;
         2'b10:   op = BOP_SUB;
         default: op = BOP_NONE;
      endcase
   end
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
   import booth_mul_pkg::*;
#(
   parameter int WIDTH          = 8,
   parameter bit SUB_VIA_INVERT = 1'b1
) (
   input  logic [WIDTH:0]   acc,
   input  logic [WIDTH-1:0] mcand,
   input  booth_op_e        op,
   output logic [WIDTH:0]   sum
);
   localparam int AW = WIDTH + 1;

   logic [AW-1:0] m_ext;
   assign m_ext = {mcand[WIDTH-1], mcand};

   generate
      if (SUB_VIA_INVERT) begin : g_invert
         logic [AW-1:0] operand;
         logic [AW-1:0] carry_in;
         always_comb begin
            case (op)
               BOP_ADD: operand = m_ext;
               BOP_SUB: operand = ~m_ext;
               default: operand = '0;
            endcase
            carry_in = {{(AW-1){1'b0}}, (op == BOP_SUB)};
         end
         assign sum = acc + operand + carry_in;
      end else begin : g_direct
         always_comb begin
            case (op)
               BOP_ADD: sum = acc + m_ext;
               BOP_SUB: sum = acc - m_ext;
               default: sum = acc;
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
   import booth_mul_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic load,
   output logic step,
   output logic busy,
   output logic done
);
   localparam int CW = $clog2(WIDTH + 1);
   localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

   mul_state_e    state_q;
   logic [CW-1:0] cnt_q;
   logic          done_q;

   assign busy = (state_q == MS_RUN);
   assign load = start && !busy;
   assign step = busy;
   assign done = done_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= MS_IDLE;
         cnt_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (load) begin
            state_q <= MS_RUN;
            cnt_q   <= '0;
         end else if (step) begin
            if (cnt_q == LAST) begin
               state_q <= MS_IDLE;
               done_q  <= 1'b1;
               cnt_q   <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
   assert_done_not_busy_R3: assert property (@(posedge clk) disable iff (rst)
      done |-> !busy);
   assert_start_taken_R2: assert property (@(posedge clk) disable iff (rst)
      (start && !busy) |=> busy);
   assert_cnt_range_R9: assert property (@(posedge clk) disable iff (rst)
      busy |-> (cnt_q < CW'(WIDTH)));
endmodule

// File: rtl/booth_seq_mul.sv
module booth_seq_mul
   import booth_mul_pkg::*;
#(
   parameter int WIDTH          = 8,
   parameter bit SUB_VIA_INVERT = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               start,
   input  logic [WIDTH-1:0]   mcand,
   input  logic [WIDTH-1:0]   mplier,
   output logic               busy,
   output logic               done,
   output logic [2*WIDTH-1:0] product
);
   localparam int AW = WIDTH + 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("booth_seq_mul: WIDTH must be at least 2");
      end
   endgenerate

   logic [AW-1:0]    acc_q;
   logic [WIDTH-1:0] mq_q;
   logic [WIDTH-1:0] mcand_q;
   logic             qx_q;
   logic             load;
   logic             step;
   logic [AW-1:0]    sum;
   booth_op_e        op;

   booth_ctrl #(.WIDTH(WIDTH)) u_ctrl (
      .clk  (clk),
      .rst  (rst),
      .start(start),
      .load (load),
      .step (step),
      .busy (busy),
      .done (done)
   );

   booth_recode u_recode (
      .cur_lsb (mq_q[0]),
      .prev_bit(qx_q),
      .op      (op)
   );

   booth_addsub #(.WIDTH(WIDTH), .SUB_VIA_INVERT(SUB_VIA_INVERT)) u_addsub (
      .acc  (acc_q),
      .mcand(mcand_q),
      .op   (op),
      .sum  (sum)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q   <= '0;
         mq_q    <= '0;
         mcand_q <= '0;
         qx_q    <= 1'b0;
      end else if (load) begin
         acc_q   <= '0;
         mq_q    <= mplier;
         mcand_q <= mcand;
         qx_q    <= 1'b0;
      end else if (step) begin
         {acc_q, mq_q, qx_q} <= {sum[AW-1], sum, mq_q};
      end
   end

   assign product = {acc_q[WIDTH-1:0], mq_q};

   assert_guard_sign_R5: assert property (@(posedge clk) disable iff (rst)
      done |-> (acc_q[AW-1] == acc_q[AW-2]));
   assert_product_hold_R8: assert property (@(posedge clk) disable iff (rst)
      (!busy && !start) |=> $stable(product));
endmodule

// File: tb/tb_booth_seq_mul.sv
module tb_booth_seq_mul;
   localparam int W  = 8;
   localparam int W5 = 5;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #5 clk = ~clk;

   logic             start = 1'b0;
   logic [W-1:0]     mcand = '0, mplier = '0;
   logic             busy, done;
   logic [2*W-1:0]   product;

   logic             start5 = 1'b0;
   logic [W5-1:0]    mcand5 = '0, mplier5 = '0;
   logic             busy5, done5;
   logic [2*W5-1:0]  product5;

   int tests = 0;
   int fails = 0;

   booth_seq_mul #(.WIDTH(W)) dut (
      .clk(clk), .rst(rst), .start(start), .mcand(mcand), .mplier(mplier),
      .busy(busy), .done(done), .product(product));

   booth_seq_mul #(.WIDTH(W5), .SUB_VIA_INVERT(1'b0)) dut5 (
      .clk(clk), .rst(rst), .start(start5), .mcand(mcand5), .mplier(mplier5),
      .busy(busy5), .done(done5), .product(product5));

   task automatic check(input string req, input longint act, input longint exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Drive one 8-bit multiplication, optionally poking start mid-run.
   task automatic mul8(input logic signed [W-1:0] a, input logic signed [W-1:0] b,
                       input string req, input bit poke);
      int n;
      longint exp;
      exp = longint'(a) * longint'(b);
      @(negedge clk);
      start = 1'b1; mcand = a; mplier = b;
      @(negedge clk);
      start = 1'b0;
      check({req, " busy after start (R2)"}, longint'(busy), 1);
      n = 0;
      while (!done && n < 4 * W) begin
         if (poke && n == 2) begin
            start = 1'b1; mcand = 8'sd3; mplier = 8'sd5;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
         n++;
      end
      start = 1'b0;
      check({req, " latency (R3)"}, longint'(n), longint'(W));
      check({req, " product"}, longint'($signed(product)), exp);
      check({req, " busy low at done (R3)"}, longint'(busy), 0);
   endtask

   task automatic mul5(input logic signed [W5-1:0] a, input logic signed [W5-1:0] b,
                       input longint exp, input string req);
      int n;
      @(negedge clk);
      start5 = 1'b1; mcand5 = a; mplier5 = b;
      @(negedge clk);
      start5 = 1'b0;
      n = 0;
      while (!done5 && n < 4 * W5) begin
         @(negedge clk);
         n++;
      end
      check({req, " 5-bit latency (R3)"}, longint'(n), longint'(W5));
      check({req, " 5-bit product (R4)"}, longint'($signed(product5)), exp);
   endtask

   task automatic test_reset();
      check("R1 busy after reset", longint'(busy), 0);
      check("R1 done after reset", longint'(done), 0);
      check("R1 product after reset", longint'(product), 0);
   endtask

   task automatic test_pulse_and_hold();
      logic [2*W-1:0] held;
      mul8(8'sd25, -8'sd7, "R4 pulse base", 1'b0);
      held = product;
      @(negedge clk);
      check("R3 done one cycle", longint'(done), 0);
      repeat (5) @(negedge clk);
      check("R8 product held", longint'(product), longint'(held));
      check("R8 done stays low", longint'(done), 0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      test_reset();
      mul5(5'sd13, -5'sd6, -78, "R4");
      mul5(-5'sd13, 5'sd11, -143, "R4");
      mul8(8'sd13, -8'sd6, "R4 pos x neg", 1'b0);
      mul8(-8'sd13, 8'sd11, "R4 neg x pos", 1'b0);
      mul8(-8'sd100, -8'sd90, "R4 neg x neg", 1'b0);
      mul8(8'sd45, 8'sd30, "R6 run multiplier 30", 1'b0);
      mul8(8'sd77, 8'sd0, "R6 zero multiplier", 1'b0);
      mul8(8'sd77, -8'sd1, "R6 all-ones multiplier", 1'b0);
      mul8(-8'sd37, 8'sh55, "R6 alternating multiplier", 1'b0);
      mul8(-8'sd128, -8'sd128, "R5 min x min", 1'b0);
      mul8(-8'sd128, 8'sd127, "R5 min mcand", 1'b0);
      mul8(8'sd127, -8'sd128, "R5 min mplier", 1'b0);
      mul8(8'sd19, -8'sd23, "R7 start while busy", 1'b1);
      test_pulse_and_hold();
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      test_reset();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule